// File: doc/BRIEF.md
# TLB Entry Allocation Unit

This block owns the write side of a 64-entry translation buffer. Each entry pairs a 64-bit tag with a 64-bit translation word. Software places entries in one of two ways. An indexed write names the slot through address bits [8:3]. An automatic fill lets the block choose the slot. For a fill, the block prefers a slot that holds no valid translation. If every slot is valid, it takes a slot that is not pinned. The tag stored with a new entry is always the value currently presented on the tag-access input. The write data becomes the translation word.

Two fault registers sit next to the array: a fault-status word and a fault-address word. A fault-status write whose bit 0 is clear wipes both registers. With bit 0 set, the write stores its data unchanged. Every write takes effect on the clock edge that samples it. The victim search is pure combinational priority logic. A read port returns any entry by index without delay.

Top module: `tlb_alloc_unit`

## Requirements
- R1: After reset every translation word and every tag reads as zero, so all entries are invalid. Both fault registers read zero and `fill_dropped` is 0.
- R2: A write with `wr_mode`=0 (indexed) selects entry `wr_addr[8:3]`. Bits [2:0] and bits above 8 are ignored. The entry's tag becomes `tag_access` and its translation word becomes `wr_data`, both visible on the read port after the next rising edge.
- R3: A write with `wr_mode`=1 (fill) goes to the lowest-numbered entry whose translation word has bit 63 equal to 0 (invalid).
- R4: If a fill finds no invalid entry, it goes to the lowest-numbered entry whose translation word has bit 6 equal to 0 (unlocked).
- R5: If every entry has bit 63 and bit 6 set, a fill changes no entry. `fill_dropped` is then 1 for the one cycle after that edge. It is 0 after any cycle with no dropped fill.
- R6: A write with `wr_mode`=2 (fault status) and `wr_data[0]`=0 sets both the fault-status and fault-address registers to zero.
- R7: A write with `wr_mode`=2 and `wr_data[0]`=1 stores `wr_data` into fault status and leaves fault address unchanged.
- R8: A write with `wr_mode`=3 stores `wr_data` into the fault-address register.
- R9: While `wr_en` is 0, no entry and no fault register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_mode | input | 2 | 0 indexed, 1 fill, 2 fault status, 3 fault address |
| wr_addr | input | 16 | Write address; bits [8:3] pick the entry for indexed writes |
| wr_data | input | 64 | Translation word or fault register data |
| tag_access | input | 64 | Tag stored with any new entry |
| rd_idx | input | 6 | Read port entry index |
| rd_tag | output | 64 | Tag of entry `rd_idx` |
| rd_tte | output | 64 | Translation word of entry `rd_idx` |
| fault_status | output | 64 | Fault-status register |
| fault_addr | output | 64 | Fault-address register |
| fill_dropped | output | 1 | A fill found no usable entry on the previous edge |

## Verification
The bound checker watches the fault registers every cycle. It checks the clear-on-bit-0 rule and the store rule for both registers. It checks that the registers hold while the strobe is low. It also checks that a drop indication only ever follows a fill. Victim choice cannot be judged from the ports in a single cycle, because it depends on the history of the whole array. That choice is left to the bench. The bench runs scenarios that leave the array with invalid slots, then with only unlocked slots, then fully pinned. It reads entries back to confirm which slot each fill landed in.

// File: rtl/tlb_alloc_pkg.sv
package tlb_alloc_pkg;

    localparam int unsigned TLB_ENTRIES   = 64;
    localparam int unsigned TLB_WORD_W    = 64;
    localparam int unsigned TLB_ADDR_W    = 16;
    localparam int unsigned TLB_VALID_POS = 63;
    localparam int unsigned TLB_LOCK_POS  = 6;
    localparam int unsigned TLB_IDX_LSB   = 3;
    localparam int unsigned TLB_KEEP_POS  = 0;

    typedef enum logic [1:0] {
        WM_INDEXED = 2'd0,
        WM_FILL    = 2'd1,
        WM_FSTAT   = 2'd2,
        WM_FADDR   = 2'd3
    } wr_mode_e;

    typedef struct packed {
        logic found;
        logic from_invalid;
    } pick_kind_t;

endpackage

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
    parameter int unsigned N_ENTRIES = tlb_alloc_pkg::TLB_ENTRIES,
    localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic [N_ENTRIES-1:0] valid_vec,
    input  logic [N_ENTRIES-1:0] lock_vec,
    output tlb_alloc_pkg::pick_kind_t kind,
    output logic [IDX_W-1:0]     victim_idx
);
    logic [N_ENTRIES-1:0] free_vec;
    logic [N_ENTRIES-1:0] unlk_vec;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_flags
        assign free_vec[g] = ~valid_vec[g];
        assign unlk_vec[g] = ~lock_vec[g];
    end

    logic             free_hit, unlk_hit;
    logic [IDX_W-1:0] free_idx, unlk_idx;

    always_comb begin
        free_hit = 1'b0;
        free_idx = '0;
        unlk_hit = 1'b0;
        unlk_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                free_hit = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (unlk_vec[i]) begin
                unlk_hit = 1'b1;
                unlk_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        kind.found        = free_hit | unlk_hit;
        kind.from_invalid = free_hit;
        victim_idx        = free_hit ? free_idx : unlk_idx;
    end
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
    parameter int unsigned N_ENTRIES = tlb_alloc_pkg::TLB_ENTRIES,
    parameter int unsigned WORD_W    = tlb_alloc_pkg::TLB_WORD_W,
    parameter int unsigned VALID_POS = tlb_alloc_pkg::TLB_VALID_POS,
    parameter int unsigned LOCK_POS  = tlb_alloc_pkg::TLB_LOCK_POS,
    localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [IDX_W-1:0]     widx,
    input  logic [WORD_W-1:0]    wtag,
    input  logic [WORD_W-1:0]    wtte,
    input  logic [IDX_W-1:0]     ridx,
    output logic [WORD_W-1:0]    rtag,
    output logic [WORD_W-1:0]    rtte,
    output logic [N_ENTRIES-1:0] valid_vec,
    output logic [N_ENTRIES-1:0] lock_vec
);
    logic [WORD_W-1:0] tag_q [N_ENTRIES];
    logic [WORD_W-1:0] tte_q [N_ENTRIES];

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q[g] <= '0;
                tte_q[g] <= '0;
            end else if (we && widx == IDX_W'(g)) begin
                tag_q[g] <= wtag;
                tte_q[g] <= wtte;
            end
        end
        assign valid_vec[g] = tte_q[g][VALID_POS];
        assign lock_vec[g]  = tte_q[g][LOCK_POS];
    end

    assign rtag = tag_q[ridx];
    assign rtte = tte_q[ridx];
endmodule

// File: rtl/tlb_fault_regs.sv
module tlb_fault_regs #(
    parameter int unsigned WORD_W   = tlb_alloc_pkg::TLB_WORD_W,
    parameter int unsigned KEEP_POS = tlb_alloc_pkg::TLB_KEEP_POS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_we,
    input  logic              addr_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] status_q,
    output logic [WORD_W-1:0] faddr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            faddr_q  <= '0;
        end else if (stat_we) begin
            if (wdata[KEEP_POS]) begin
                status_q <= wdata;
            end else begin
                status_q <= '0;
                faddr_q  <= '0;
            end
        end else if (addr_we) begin
            faddr_q <= wdata;
        end
    end
endmodule

// File: rtl/tlb_alloc_unit.sv
module tlb_alloc_unit
    import tlb_alloc_pkg::*;
#(
    parameter int unsigned N_ENTRIES = TLB_ENTRIES,
    parameter int unsigned WORD_W    = TLB_WORD_W,
    parameter int unsigned ADDR_W    = TLB_ADDR_W,
    parameter int unsigned VALID_POS = TLB_VALID_POS,
    parameter int unsigned LOCK_POS  = TLB_LOCK_POS,
    parameter int unsigned IDX_LSB   = TLB_IDX_LSB,
    parameter int unsigned KEEP_POS  = TLB_KEEP_POS,
    localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_mode,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] tag_access,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_tag,
    output logic [WORD_W-1:0] rd_tte,
    output logic [WORD_W-1:0] fault_status,
    output logic [WORD_W-1:0] fault_addr,
    output logic              fill_dropped
);
    localparam int unsigned IDX_MSB = IDX_LSB + IDX_W - 1;

    wr_mode_e         mode;
    logic [IDX_W-1:0] addr_idx;
    logic             unused_addr_bits;

    assign mode     = wr_mode_e'(wr_mode);
    assign addr_idx = wr_addr[IDX_MSB:IDX_LSB];
    assign unused_addr_bits = ^{wr_addr[ADDR_W-1:IDX_MSB+1], wr_addr[IDX_LSB-1:0]};

    logic [N_ENTRIES-1:0] valid_vec, lock_vec;
    pick_kind_t           pick;
    logic [IDX_W-1:0]     victim_idx;

    tlb_victim_pick #(
        .N_ENTRIES (N_ENTRIES)
    ) u_pick (
        .valid_vec  (valid_vec),
        .lock_vec   (lock_vec),
        .kind       (pick),
        .victim_idx (victim_idx)
    );

    logic             store_we;
    logic [IDX_W-1:0] store_idx;
    logic             drop_now;

    always_comb begin
        store_we  = 1'b0;
        store_idx = addr_idx;
        drop_now  = 1'b0;
        if (wr_en) begin
            unique case (mode)
                WM_INDEXED: store_we = 1'b1;
                WM_FILL: begin
                    store_idx = victim_idx;
                    store_we  = pick.found;
                    drop_now  = ~pick.found;
                end
                default: ;
            endcase
        end
    end

    tlb_entry_store #(
        .N_ENTRIES (N_ENTRIES),
        .WORD_W    (WORD_W),
        .VALID_POS (VALID_POS),
        .LOCK_POS  (LOCK_POS)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .we        (store_we),
        .widx      (store_idx),
        .wtag      (tag_access),
        .wtte      (wr_data),
        .ridx      (rd_idx),
        .rtag      (rd_tag),
        .rtte      (rd_tte),
        .valid_vec (valid_vec),
        .lock_vec  (lock_vec)
    );

    tlb_fault_regs #(
        .WORD_W   (WORD_W),
        .KEEP_POS (KEEP_POS)
    ) u_fault (
        .clk      (clk),
        .rst      (rst),
        .stat_we  (wr_en && mode == WM_FSTAT),
        .addr_we  (wr_en && mode == WM_FADDR),
        .wdata    (wr_data),
        .status_q (fault_status),
        .faddr_q  (fault_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) fill_dropped <= 1'b0;
        else     fill_dropped <= drop_now;
    end
endmodule

// File: rtl/tlb_alloc_unit_chk.sv
module tlb_alloc_unit_chk #(
    parameter int unsigned WORD_W   = 64,
    parameter int unsigned KEEP_POS = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_mode,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] fault_status,
    input logic [WORD_W-1:0] fault_addr,
    input logic              fill_dropped
);
    AST_FSTAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_mode == 2'd2 && !wr_data[KEEP_POS]) |=> (fault_status == '0 && fault_addr == '0)); // R6

    AST_FSTAT_STORE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_mode == 2'd2 && wr_data[KEEP_POS]) |=> (fault_status == $past(wr_data) && $stable(fault_addr))); // R7

    AST_FADDR_STORE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_mode == 2'd3) |=> (fault_addr == $past(wr_data) && $stable(fault_status))); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(fault_status) && $stable(fault_addr))); // R9

    AST_DROP_NEEDS_FILL: assert property (@(posedge clk) disable iff (rst)
        fill_dropped |-> $past(wr_en && wr_mode == 2'd1)); // R5
endmodule

bind tlb_alloc_unit tlb_alloc_unit_chk #(
    .WORD_W   (WORD_W),
    .KEEP_POS (KEEP_POS)
) u_chk (.*);

// File: tb/tb_tlb_alloc_unit.sv
module tb_tlb_alloc_unit;
    localparam logic [63:0] VLD = 64'h8000_0000_0000_0000;
    localparam logic [63:0] LCK = 64'h0000_0000_0000_0040;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_mode = 2'd0;
    logic [15:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] tag_access = '0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_tag, rd_tte, fault_status, fault_addr;
    logic        fill_dropped;

    always #5 clk = ~clk;

    tlb_alloc_unit dut (.*);

    typedef enum int { K_ENTRY, K_FAULT, K_DROP } kind_e;
    typedef struct {
        kind_e       kind;
        string       req;
        int          idx;
        logic [63:0] a;
        logic [63:0] b;
    } item_t;

    item_t sb_q[$];
    bit    mon_busy = 1'b0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    task automatic report(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected items and compares them against the ports
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            mon_busy = 1'b1;
            begin
                item_t it;
                it = sb_q.pop_front();
                case (it.kind)
                    K_DROP: report(it.req, "fill_dropped", {63'd0, fill_dropped}, it.a);
                    K_FAULT: begin
                        report(it.req, "fault_status", fault_status, it.a);
                        report(it.req, "fault_addr", fault_addr, it.b);
                    end
                    default: begin
                        rd_idx = 6'(it.idx);
                        #1;
                        report(it.req, $sformatf("tag[%0d]", it.idx), rd_tag, it.a);
                        report(it.req, $sformatf("tte[%0d]", it.idx), rd_tte, it.b);
                    end
                endcase
            end
            mon_busy = 1'b0;
        end
    end

    task automatic expect_item(kind_e k, string req, int idx, logic [63:0] a, logic [63:0] b);
        item_t it;
        it.kind = k; it.req = req; it.idx = idx; it.a = a; it.b = b;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        wait (sb_q.size() == 0 && !mon_busy);
    endtask

    task automatic do_write(logic [1:0] m, logic [15:0] addr, logic [63:0] data, logic [63:0] tag);
        @(negedge clk);
        wr_en = 1'b1; wr_mode = m; wr_addr = addr; wr_data = data; tag_access = tag;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] at(int idx);
        return 16'(idx << 3);
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        expect_item(K_DROP, "R1", 0, 64'd0, 64'd0);
        expect_item(K_FAULT, "R1", 0, 64'd0, 64'd0);
        expect_item(K_ENTRY, "R1", 0, 64'd0, 64'd0);
        expect_item(K_ENTRY, "R1", 63, 64'd0, 64'd0);
        drain();

        // R2 indexed writes, low/high address bits ignored
        do_write(2'd0, at(5) | 16'h7, VLD | 64'h55, 64'hA5);
        do_write(2'd0, at(63), VLD | 64'h63, 64'hB63);
        do_write(2'd0, 16'h0200 | at(2), VLD | 64'h22, 64'hC2);
        expect_item(K_ENTRY, "R2", 5, 64'hA5, VLD | 64'h55);
        expect_item(K_ENTRY, "R2", 63, 64'hB63, VLD | 64'h63);
        expect_item(K_ENTRY, "R2", 2, 64'hC2, VLD | 64'h22);
        drain();

        // R3 fills go to lowest invalid: 0, 1, then 3 (2 is valid)
        do_write(2'd1, 16'hFFF8, VLD | 64'h100, 64'hF0);
        do_write(2'd1, 16'h0000, VLD | 64'h101, 64'hF1);
        do_write(2'd1, 16'h0000, VLD | 64'h103, 64'hF3);
        expect_item(K_ENTRY, "R3", 0, 64'hF0, VLD | 64'h100);
        expect_item(K_ENTRY, "R3", 1, 64'hF1, VLD | 64'h101);
        expect_item(K_ENTRY, "R3", 3, 64'hF3, VLD | 64'h103);
        expect_item(K_ENTRY, "R3", 2, 64'hC2, VLD | 64'h22);
        drain();

        // R9 strobe low: nothing changes
        @(negedge clk);
        wr_mode = 2'd0; wr_addr = at(4); wr_data = VLD | 64'hDEAD; tag_access = 64'hBAD;
        @(negedge clk);
        wr_mode = 2'd3;
        @(negedge clk);
        expect_item(K_ENTRY, "R9", 4, 64'd0, 64'd0);
        expect_item(K_FAULT, "R9", 0, 64'd0, 64'd0);
        drain();

        // R4 fill array valid+locked except 10 and 20 (valid, unlocked)
        for (int i = 0; i < 64; i++) begin
            if (i == 10 || i == 20) do_write(2'd0, at(i), VLD | 64'(i), 64'(i));
            else                    do_write(2'd0, at(i), VLD | LCK | 64'(i), 64'(i));
        end
        do_write(2'd1, '0, VLD | LCK | 64'h1000, 64'hE10);
        expect_item(K_DROP, "R4", 0, 64'd0, 64'd0);
        expect_item(K_ENTRY, "R4", 10, 64'hE10, VLD | LCK | 64'h1000);
        expect_item(K_ENTRY, "R4", 20, 64'd20, VLD | 64'd20);
        drain();
        do_write(2'd1, '0, VLD | LCK | 64'h2000, 64'hE20);
        expect_item(K_ENTRY, "R4", 20, 64'hE20, VLD | LCK | 64'h2000);
        drain();

        // R5 all pinned: dropped, one-cycle flag, no entry changed
        do_write(2'd1, '0, 64'h1234, 64'h777);
        expect_item(K_DROP, "R5", 0, 64'd1, 64'd0);
        drain();
        expect_item(K_ENTRY, "R5", 0, 64'd0, VLD | LCK);
        expect_item(K_ENTRY, "R5", 33, 64'd33, VLD | LCK | 64'd33);
        drain();
        @(negedge clk);
        expect_item(K_DROP, "R5", 0, 64'd0, 64'd0);
        drain();

        // R8 fault address write
        do_write(2'd3, '0, 64'hFACE_0000_1111_2222, '0);
        expect_item(K_FAULT, "R8", 0, 64'd0, 64'hFACE_0000_1111_2222);
        drain();

        // R7 status with bit 0 set is stored, address kept
        do_write(2'd2, '0, 64'h0000_00AB_0000_0081, '0);
        expect_item(K_FAULT, "R7", 0, 64'h0000_00AB_0000_0081, 64'hFACE_0000_1111_2222);
        drain();

        // R6 status with bit 0 clear wipes both
        do_write(2'd2, '0, 64'hFFFF_FFFF_FFFF_FFFE, '0);
        expect_item(K_FAULT, "R6", 0, 64'd0, 64'd0);
        drain();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule